// File: doc/BRIEF.md
# Pipelined Burst Static RAM with Byte Masking

This block models a synchronous static RAM with a 64-bit data path, a parameterised depth and one pipeline register on the read path. A cycle begins when an address is captured by one of two active-low strobes. One strobe is meant for a processor and is honoured only while the chip is already selected. The other is meant for a memory controller and always loads. After the load, an internal two-bit counter supplies the remaining beats of a four-beat burst. The counter advances once for each cycle in which the step input is low. A static order input chooses the sequence: linear, where the low address bits count up and wrap, or interleaved, where the start bits are XORed with the beat count.

Every cycle in which the chip is selected is one access at the current address. It is a write if any byte is enabled and a read otherwise. Write data and write controls are captured on the same edge as the address. The array is then updated internally, with no handshake. A one-entry write buffer holds the most recent write until the next edge. A read of the same address merges that buffer byte by byte, so a read issued directly after a write returns the new data. Read data comes out of a register one cycle after its address. The output drive enable is that registered read flag gated by an asynchronous active-low output enable. The undriven bus reads as zero.

Top module: `pburst_sram`

## Requirements
- R1: A low `ctrl_stb_n` on a clock edge loads `addr_i` and the three select inputs, whatever the other control inputs are, and restarts the burst at beat 0. The access address in the next cycle equals the loaded address.
- R2: A low `proc_stb_n` (with `ctrl_stb_n` high) loads the address and the selects only if the registered select is active. Otherwise it is ignored: the chip stays deselected and nothing is driven.
- R3: While `ctrl_stb_n`, `proc_stb_n` and `burst_step_n` are all high, the access address and the registered select hold. A selected read repeats at the same address.
- R4: With `order_ilv`=0, each low `burst_step_n` steps the two low address bits by +1 modulo 4 (start 1 gives 1,2,3,0, then 1). The upper address bits never change during a burst.
- R5: With `order_ilv`=1, the low address bits are start XOR beat count (start 2 gives 2,3,0,1; start 1 gives 1,0,3,2).
- R6: `wr_all_n` low makes the cycle a write of all eight bytes, whatever `byte_sel_n` and `byte_wr_en_n` are.
- R7: Bit n-1 of `byte_sel_n` (n = 1..8), when low, writes data bits 8n-8 to 8n-1, but only while `byte_wr_en_n` is low. With `byte_wr_en_n` high and `wr_all_n` high, no byte is written and the cycle is a read.
- R8: A selected read whose address is registered on edge k presents its data on `rdata_o`, with `rdata_drv_o` high, from edge k+1 until edge k+2, and not before.
- R9: A read in the cycle right after a write to the same address returns the newly written bytes merged with the older contents (write pass-through).
- R10: The chip is selected only if the select inputs captured at a load are `sel_a_n`=0, `sel_b`=1, `sel_c_n`=0. A deselected cycle neither writes the array nor drives the bus.
- R11: `rdata_drv_o` equals the pipelined read flag ANDed with the inverse of `out_en_n`, combinationally. `rdata_o` is zero whenever `rdata_drv_o` is low.
- R12: Synchronous reset leaves the chip deselected, `rdata_drv_o` low and `rdata_o` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Address captured by a strobe |
| ctrl_stb_n | input | 1 | Controller address strobe, active low, always loads |
| proc_stb_n | input | 1 | Processor address strobe, active low, loads only while selected |
| burst_step_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Select input, active low |
| sel_b | input | 1 | Select input, active high |
| sel_c_n | input | 1 | Select input, active low |
| order_ilv | input | 1 | Static burst order: 1 interleaved, 0 linear |
| wr_all_n | input | 1 | Write all bytes, active low |
| byte_wr_en_n | input | 1 | Qualifies the per-byte enables, active low |
| byte_sel_n | input | NBYTES | Per-byte write enables, active low, bit 0 is the lowest byte |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | NBYTES*BYTE_W | Write data |
| rdata_o | output | NBYTES*BYTE_W | Read data, zero when not driven |
| rdata_drv_o | output | 1 | Bus drive enable |

## Verification
Two functions can act in the same cycle. The first is the commit of the buffered write into the array. The second is a read of that same address, which must take the buffered bytes and not the stale array word. The bench provokes this by following a write at once with a read of that address, through a fresh controller load and through a held address. It includes a partial byte write, so the result mixes bytes from both sources. A scoreboard built from a byte-level reference model judges each returned word in order. Controller and processor strobes are also asserted together to show that the controller load wins.

// File: rtl/pburst_pkg.sv
package pburst_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2
  } addr_act_e;

  // low two address bits for a given beat of a four-beat burst
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       ilv);
    logic [1:0] sum;
    sum = start + beat;
    return ilv ? (start ^ beat) : sum;
  endfunction

endpackage

// File: rtl/pburst_addr_gen.sv
module pburst_addr_gen
  import pburst_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ctrl_stb_n,
  input  logic              proc_stb_n,
  input  logic              burst_step_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              order_ilv,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              sel_q
);

  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  addr_act_e         act;

  always_comb begin
    if (!ctrl_stb_n)                act = ACT_LOAD;
    else if (!proc_stb_n && sel_q)  act = ACT_LOAD;
    else if (!burst_step_n)         act = ACT_STEP;
    else                            act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      unique case (act)
        ACT_LOAD: begin
          base_q <= addr_i;
          beat_q <= '0;
          sel_q  <= !sel_a_n && sel_b && !sel_c_n;
        end
        ACT_STEP: beat_q <= beat_q + 2'd1;
        default:  ;
      endcase
    end
  end

  logic [HI_W-1:0] hi_bits;
  assign hi_bits  = base_q[ADDR_W-1:2];
  assign acc_addr = {hi_bits, beat_low(base_q[1:0], beat_q, order_ilv)};

endmodule

// File: rtl/pburst_wr_ctrl.sv
module pburst_wr_ctrl #(
  parameter int NBYTES = 8,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_all_n,
  input  logic                     byte_wr_en_n,
  input  logic [NBYTES-1:0]        byte_sel_n,
  input  logic [NBYTES*BYTE_W-1:0] wdata_i,
  output logic [NBYTES-1:0]        mask_q,
  output logic [NBYTES*BYTE_W-1:0] wdata_q
);

  logic [NBYTES-1:0] mask_d;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign mask_d[b] = !wr_all_n || (!byte_wr_en_n && !byte_sel_n[b]);
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_d;
  end

  always_ff @(posedge clk) begin
    wdata_q <= wdata_i;
  end

endmodule

// File: rtl/pburst_array.sv
module pburst_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 8,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sel_q,
  input  logic [ADDR_W-1:0]        acc_addr,
  input  logic [NBYTES-1:0]        mask_q,
  input  logic [NBYTES*BYTE_W-1:0] wdata_q,
  output logic [NBYTES*BYTE_W-1:0] rd_data,
  output logic                     rd_vld_q
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = NBYTES * BYTE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic              do_wr, do_rd;
  logic              wb_vld_q;
  logic [ADDR_W-1:0] wb_addr_q;
  logic [NBYTES-1:0] wb_mask_q;
  logic [DATA_W-1:0] wb_data_q;

  logic              byp_hit_q;
  logic [NBYTES-1:0] byp_mask_q;
  logic [DATA_W-1:0] byp_data_q;
  logic [DATA_W-1:0] rd_mem_q;

  assign do_wr = sel_q && (|mask_q);
  assign do_rd = sel_q && !(|mask_q);

  // array: commit buffered write, synchronous read of the old word
  always_ff @(posedge clk) begin
    if (wb_vld_q) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (wb_mask_q[b])
          mem[wb_addr_q][b*BYTE_W +: BYTE_W] <= wb_data_q[b*BYTE_W +: BYTE_W];
      end
    end
    rd_mem_q <= mem[acc_addr];
  end

  // one-entry write buffer
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_vld_q <= 1'b0;
    end else begin
      wb_vld_q <= do_wr;
    end
    wb_addr_q <= acc_addr;
    wb_mask_q <= mask_q;
    wb_data_q <= wdata_q;
  end

  // pass-through capture and pipelined read flag
  always_ff @(posedge clk) begin
    if (rst) begin
      byp_hit_q <= 1'b0;
      rd_vld_q  <= 1'b0;
    end else begin
      byp_hit_q <= do_rd && wb_vld_q && (wb_addr_q == acc_addr);
      rd_vld_q  <= do_rd;
    end
    byp_mask_q <= wb_mask_q;
    byp_data_q <= wb_data_q;
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_merge
    assign rd_data[b*BYTE_W +: BYTE_W] = (byp_hit_q && byp_mask_q[b])
                                         ? byp_data_q[b*BYTE_W +: BYTE_W]
                                         : rd_mem_q[b*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/pburst_sram.sv
module pburst_sram #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 8,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     ctrl_stb_n,
  input  logic                     proc_stb_n,
  input  logic                     burst_step_n,
  input  logic                     sel_a_n,
  input  logic                     sel_b,
  input  logic                     sel_c_n,
  input  logic                     order_ilv,
  input  logic                     wr_all_n,
  input  logic                     byte_wr_en_n,
  input  logic [NBYTES-1:0]        byte_sel_n,
  input  logic                     out_en_n,
  input  logic [NBYTES*BYTE_W-1:0] wdata_i,
  output logic [NBYTES*BYTE_W-1:0] rdata_o,
  output logic                     rdata_drv_o
);

  localparam int DATA_W = NBYTES * BYTE_W;

  logic [ADDR_W-1:0] acc_addr;
  logic              sel_q;
  logic [NBYTES-1:0] mask_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_data;
  logic              rd_vld_q;

  pburst_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk          (clk),
    .rst          (rst),
    .addr_i       (addr_i),
    .ctrl_stb_n   (ctrl_stb_n),
    .proc_stb_n   (proc_stb_n),
    .burst_step_n (burst_step_n),
    .sel_a_n      (sel_a_n),
    .sel_b        (sel_b),
    .sel_c_n      (sel_c_n),
    .order_ilv    (order_ilv),
    .acc_addr     (acc_addr),
    .sel_q        (sel_q)
  );

  pburst_wr_ctrl #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_wr (
    .clk          (clk),
    .rst          (rst),
    .wr_all_n     (wr_all_n),
    .byte_wr_en_n (byte_wr_en_n),
    .byte_sel_n   (byte_sel_n),
    .wdata_i      (wdata_i),
    .mask_q       (mask_q),
    .wdata_q      (wdata_q)
  );

  pburst_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_arr (
    .clk      (clk),
    .rst      (rst),
    .sel_q    (sel_q),
    .acc_addr (acc_addr),
    .mask_q   (mask_q),
    .wdata_q  (wdata_q),
    .rd_data  (rd_data),
    .rd_vld_q (rd_vld_q)
  );

  assign rdata_drv_o = rd_vld_q && !out_en_n;
  assign rdata_o     = rdata_drv_o ? rd_data : '0;

endmodule

// File: rtl/pburst_sram_chk.sv
module pburst_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ctrl_stb_n,
  input logic              proc_stb_n,
  input logic              burst_step_n,
  input logic              wr_all_n,
  input logic              byte_wr_en_n,
  input logic              out_en_n,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              sel_q,
  input logic [NBYTES-1:0] mask_q,
  input logic              rdata_drv_o
);

  p_ctrl_load_r1: assert property (@(posedge clk) disable iff (rst)
    !ctrl_stb_n |=> acc_addr == $past(addr_i));

  p_proc_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    ctrl_stb_n && !proc_stb_n && !sel_q && burst_step_n |=> $stable(acc_addr) && !sel_q);

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    ctrl_stb_n && proc_stb_n && burst_step_n |=> $stable(acc_addr) && $stable(sel_q));

  p_upper_kept_r4: assert property (@(posedge clk) disable iff (rst)
    ctrl_stb_n && (proc_stb_n || !sel_q) && !burst_step_n
    |=> acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2])
        && acc_addr[1:0] != $past(acc_addr[1:0]));

  p_write_all_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_all_n |=> &mask_q);

  p_byte_gate_r7: assert property (@(posedge clk) disable iff (rst)
    wr_all_n && byte_wr_en_n |=> mask_q == '0);

  p_oe_release_r11: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> !rdata_drv_o);

  p_reset_state_r12: assert property (@(posedge clk)
    rst |=> !sel_q && !rdata_drv_o);

endmodule

bind pburst_sram pburst_sram_chk #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .addr_i       (addr_i),
  .ctrl_stb_n   (ctrl_stb_n),
  .proc_stb_n   (proc_stb_n),
  .burst_step_n (burst_step_n),
  .wr_all_n     (wr_all_n),
  .byte_wr_en_n (byte_wr_en_n),
  .out_en_n     (out_en_n),
  .acc_addr     (acc_addr),
  .sel_q        (sel_q),
  .mask_q       (mask_q),
  .rdata_drv_o  (rdata_drv_o)
);

// File: tb/sim_pburst_sram.sv
module sim_pburst_sram;
  localparam int AW = 6;
  localparam int NB = 8;
  localparam int BW = 8;
  localparam int DW = NB * BW;
  localparam logic [2:0] SEL = 3'b010;  // {sel_a_n, sel_b, sel_c_n}
  localparam logic [2:0] DES = 3'b110;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic          ctrl_stb_n = 1'b1, proc_stb_n = 1'b1, burst_step_n = 1'b1;
  logic          sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic          order_ilv = 1'b0;
  logic          wr_all_n = 1'b1, byte_wr_en_n = 1'b1;
  logic [NB-1:0] byte_sel_n = '1;
  logic          out_en_n = 1'b0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          rdata_drv_o;

  always #10 clk = ~clk;

  pburst_sram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW)) u0 (
    .clk(clk), .rst(rst), .addr_i(addr_i), .ctrl_stb_n(ctrl_stb_n),
    .proc_stb_n(proc_stb_n), .burst_step_n(burst_step_n), .sel_a_n(sel_a_n),
    .sel_b(sel_b), .sel_c_n(sel_c_n), .order_ilv(order_ilv), .wr_all_n(wr_all_n),
    .byte_wr_en_n(byte_wr_en_n), .byte_sel_n(byte_sel_n), .out_en_n(out_en_n),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rdata_drv_o(rdata_drv_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] ref_mem [1<<AW];
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  logic          m_sel = 1'b0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;

  function automatic logic [DW-1:0] pat(input int i);
    return {NB{8'(i * 7 + 3)}} ^ {8'(i), 48'h0, 8'(255 - i)};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor, samples 5 ns after each falling edge
  initial forever begin
    @(negedge clk);
    #5;
    if (!rst && rdata_drv_o) begin
      if (exp_q.size() == 0) begin
        chk("R10", 64'd1, 64'd0);  // drive with nothing expected
      end else begin
        chk(tag_q.pop_front(), rdata_o, exp_q.pop_front());
      end
    end
  end

  // driver: one cycle of stimulus, reference model updated alongside
  task automatic cyc(input logic c_n, input logic p_n, input logic s_n, input logic [2:0] cs,
                     input logic g_n, input logic b_n, input logic [NB-1:0] bs_n,
                     input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    logic [1:0]    lo;
    logic [AW-1:0] acc;
    logic [NB-1:0] msk;
    ctrl_stb_n = c_n; proc_stb_n = p_n; burst_step_n = s_n;
    {sel_a_n, sel_b, sel_c_n} = cs;
    wr_all_n = g_n; byte_wr_en_n = b_n; byte_sel_n = bs_n;
    addr_i = a; wdata_i = d;
    if (!c_n || (!p_n && m_sel)) begin
      m_base = a; m_beat = 2'd0; m_sel = (cs == SEL);
    end else if (!s_n) begin
      m_beat = m_beat + 2'd1;
    end
    lo  = order_ilv ? (m_base[1:0] ^ m_beat) : 2'(m_base[1:0] + m_beat);
    acc = {m_base[AW-1:2], lo};
    for (int b = 0; b < NB; b++) msk[b] = !g_n || (!b_n && !bs_n[b]);
    if (m_sel) begin
      if (|msk) begin
        for (int b = 0; b < NB; b++)
          if (msk[b]) ref_mem[acc][b*BW +: BW] = d[b*BW +: BW];
      end else begin
        exp_q.push_back(ref_mem[acc]);
        tag_q.push_back(req);
      end
    end
    @(negedge clk);
  endtask

  task automatic ld_rd(input logic [AW-1:0] a, input string req);
    cyc(1'b0, 1'b1, 1'b1, SEL, 1'b1, 1'b1, '1, a, '0, req);
  endtask
  task automatic ld_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    cyc(1'b0, 1'b1, 1'b1, SEL, 1'b0, 1'b1, '1, a, d, req);
  endtask
  task automatic step_rd(input string req);
    cyc(1'b1, 1'b1, 1'b0, SEL, 1'b1, 1'b1, '1, '0, '0, req);
  endtask
  task automatic step_wr(input logic [DW-1:0] d, input string req);
    cyc(1'b1, 1'b1, 1'b0, SEL, 1'b0, 1'b1, '1, '0, d, req);
  endtask
  task automatic hold(input string req);
    cyc(1'b1, 1'b1, 1'b1, SEL, 1'b1, 1'b1, '1, '0, '0, req);
  endtask
  task automatic idle();
    cyc(1'b0, 1'b1, 1'b1, DES, 1'b1, 1'b1, '1, '0, '0, "R10");
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R12 drive", 64'(rdata_drv_o), 64'd0);
    chk("R12 data", rdata_o, '0);
    #1;

    // R6: fill with full-word writes, byte enables deliberately off
    for (int i = 0; i < 32; i++) ld_wr(AW'(i), pat(i), "R6");
    // R1: single controller loads read back
    for (int i = 0; i < 16; i++) ld_rd(AW'(i), "R1");

    // R8: latency of a lone read
    idle(); idle();
    ld_rd(6'd17, "R8");
    #6 chk("R8 not early", 64'(rdata_drv_o), 64'd0);
    idle();
    #6 chk("R8 on time", rdata_o, ref_mem[17]);
    idle();
    #6 chk("R8 one beat only", 64'(rdata_drv_o), 64'd0);

    // R4: linear burst from 9 -> 9,10,11,8,9
    order_ilv = 1'b0;
    ld_rd(6'd9, "R4");
    repeat (4) step_rd("R4");
    // R5: interleaved from 6 -> 6,7,4,5 and from 13 -> 13,12,15,14
    idle();
    order_ilv = 1'b1;
    ld_rd(6'd6, "R5");
    repeat (3) step_rd("R5");
    ld_rd(6'd13, "R5");
    repeat (3) step_rd("R5");
    idle();
    order_ilv = 1'b0;

    // R4: burst write 22,23,20,21 then read back
    ld_wr(6'd22, pat(100), "R4");
    step_wr(pat(101), "R4");
    step_wr(pat(102), "R4");
    step_wr(pat(103), "R4");
    ld_rd(6'd20, "R4");
    repeat (3) step_rd("R4");

    // R7: byte 1 only, then byte 8 only, then gated-off enables
    cyc(1'b0, 1'b1, 1'b1, SEL, 1'b1, 1'b0, 8'b1111_1110, 6'd3, {NB{8'hAA}}, "R7");
    ld_rd(6'd3, "R7");
    cyc(1'b0, 1'b1, 1'b1, SEL, 1'b1, 1'b0, 8'b0111_1111, 6'd4, {NB{8'h55}}, "R7");
    ld_rd(6'd4, "R7");
    cyc(1'b0, 1'b1, 1'b1, SEL, 1'b1, 1'b1, 8'h00, 6'd5, {NB{8'h33}}, "R7");
    ld_rd(6'd5, "R7");
    // R6: global write overrides disabled byte enables
    cyc(1'b0, 1'b1, 1'b1, SEL, 1'b0, 1'b0, 8'hFF, 6'd7, {NB{8'hC3}}, "R6");
    ld_rd(6'd7, "R6");

    // R9: write then read same address at once; partial write merges
    ld_wr(6'd11, pat(200), "R9");
    ld_rd(6'd11, "R9");
    cyc(1'b0, 1'b1, 1'b1, SEL, 1'b1, 1'b0, 8'b1010_0101, 6'd12, {NB{8'h7E}}, "R9");
    hold("R9");
    ld_wr(6'd12, pat(201), "R9");
    cyc(1'b0, 1'b1, 1'b1, SEL, 1'b1, 1'b0, 8'b1111_0000, 6'd13, {NB{8'h19}}, "R9");
    ld_rd(6'd12, "R9");
    ld_rd(6'd13, "R9");

    // R3: held address repeats; controller wins over processor strobe
    ld_rd(6'd14, "R3");
    repeat (3) hold("R3");
    cyc(1'b0, 1'b0, 1'b0, SEL, 1'b1, 1'b1, '1, 6'd15, '0, "R1");

    // R2: processor load while selected works
    cyc(1'b1, 1'b0, 1'b1, SEL, 1'b1, 1'b1, '1, 6'd16, '0, "R2");
    idle();
    // R2: processor load while deselected is ignored
    cyc(1'b1, 1'b0, 1'b1, SEL, 1'b1, 1'b1, '1, 6'd16, '0, "R2");
    hold("R2");
    #6 chk("R2 ignored", 64'(rdata_drv_o), 64'd0);

    // R10: deselected writes do nothing, each select input tested
    cyc(1'b0, 1'b1, 1'b1, 3'b110, 1'b0, 1'b1, '1, 6'd2, {NB{8'hEE}}, "R10");
    cyc(1'b0, 1'b1, 1'b1, 3'b000, 1'b0, 1'b1, '1, 6'd2, {NB{8'hEE}}, "R10");
    cyc(1'b0, 1'b1, 1'b1, 3'b011, 1'b0, 1'b1, '1, 6'd2, {NB{8'hEE}}, "R10");
    #6 chk("R10 no drive", 64'(rdata_drv_o), 64'd0);
    ld_rd(6'd2, "R10");

    // R11: asynchronous output enable
    ld_rd(6'd1, "R11");
    hold("R11");
    #7 out_en_n = 1'b1;
    #1 chk("R11 release", 64'(rdata_drv_o), 64'd0);
    chk("R11 zero bus", rdata_o, '0);
    out_en_n = 1'b0;
    #1 chk("R11 drive", 64'(rdata_drv_o), 64'd1);
    idle(); idle(); idle();

    chk("R8 all reads returned", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule